// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Status Word

This block is the arithmetic part of the execute stage of a small 32-bit core. Each cycle in which the issue strobe is high, it takes a 6-bit opcode, two source operands and a 16-bit immediate. One clock edge later it presents a result, a one-cycle write-enable for the destination register, and an updated status word. The status word is the contents of register 0 of the core.

The unit covers eight operations. There are signed and unsigned forms of add and subtract, and signed and unsigned forms of add-immediate. There is also a three-way signed compare that writes a one-hot code, and a multiply that keeps only the low word of the product.

The status word holds four flags at fixed bit positions that the rest of the core decodes: parity, zero, sign and overflow. Every other bit of the status word is zero. An opcode outside the arithmetic group does not write the destination register and does not change the status word, so other execute units can share the opcode bus.

Top module: `alu_exec_core`

## Requirements
- R1: Opcode values select the operation: 0 is signed add, 1 is unsigned add, 2 is signed subtract, 3 is unsigned subtract, 4 is signed add-immediate, 5 is unsigned add-immediate, 6 is compare and 7 is multiply. Every result wraps to 32 bits, and multiply returns the low 32 bits of the product.
- R2: In the status word, parity is bit 2, zero is bit 6, sign is bit 7 and overflow is bit 11. All other status bits are always 0.
- R3: Opcodes 0, 2 and 4 set the overflow bit exactly when the true signed result does not fit in 32 bits.
- R4: Opcodes 1, 3, 5, 6 and 7 always clear the overflow bit.
- R5: Compare treats both sources as signed. It writes 1 when the first source is smaller, 2 when the sources are equal and 4 when the first source is larger.
- R6: The add-immediate opcodes sign-extend the 16-bit immediate to 32 bits and add it to the first source. The second source is ignored.
- R7: The parity bit is 1 when the low 8 bits of the result contain an even number of ones.
- R8: The zero bit is 1 when the 32-bit result is 0. The sign bit equals bit 31 of the result. Both bits are updated by every opcode from 0 to 7.
- R9: An opcode from 8 to 63 leaves the write-enable low, and leaves the result and the status word unchanged.
- R10: Result, write-enable and status change on the clock edge that samples the strobe. The write-enable is high for exactly one cycle per accepted opcode. With the strobe low, the write-enable is 0 and the result and status are held.
- R11: While reset is asserted, and until reset has been released, the result, write-enable and status are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Issue strobe for the opcode and operands |
| opcode | input | 6 | Operation select |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| imm | input | 16 | Immediate for the add-immediate opcodes |
| result | output | 32 | Value to write to the destination register |
| rd_we | output | 1 | Destination write-enable, one cycle per accepted opcode |
| status | output | 32 | Status word, the contents of register 0 |

## Verification
The bench applies all 64 opcode values to operand sets that sit at the signed boundaries. These include the largest positive value plus one, the most negative value minus one, equal operands, and immediates of 0x7FFF and 0x8000.

A design that tests overflow on the unsigned sum, or that does not clear overflow for the non-overflow opcodes, leaves the wrong value in bit 11. A compare that is unsigned swaps the less and greater codes whenever the operand signs differ. A zero-extended immediate turns 0x8000 into a positive addend. A parity flag with the wrong polarity shows up on every result. The illegal-opcode sweep catches a design that writes the destination or the status word on an opcode outside the group.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 6'd0,
    OP_ADDU  = 6'd1,
    OP_SUB   = 6'd2,
    OP_SUBU  = 6'd3,
    OP_ADDI  = 6'd4,
    OP_ADDIU = 6'd5,
    OP_CMP   = 6'd6,
    OP_MUL   = 6'd7
  } alu_op_e;

  // flag positions decoded by the branch unit
  localparam int ST_PAR_BIT  = 2;
  localparam int ST_ZERO_BIT = 6;
  localparam int ST_SIGN_BIT = 7;
  localparam int ST_OVF_BIT  = 11;

  localparam logic [2:0] CMP_LT = 3'b001;
  localparam logic [2:0] CMP_EQ = 3'b010;
  localparam logic [2:0] CMP_GT = 3'b100;

  typedef struct packed {
    logic par;
    logic zero;
    logic sign;
    logic ovf;
  } alu_flags_t;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res,
  output logic              ovf,
  output logic              legal
);

  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] cmp_word;
  logic              use_imm;
  logic              sum_ovf;
  logic              diff_ovf;
  logic              a_lt_b;
  logic              a_eq_b;

  always_comb begin
    imm_ext  = {{EXT_W{imm[IMM_W-1]}}, imm};
    use_imm  = (opcode == OP_ADDI) || (opcode == OP_ADDIU);
    addend   = use_imm ? imm_ext : src_b;
    sum      = src_a + addend;
    diff     = src_a - src_b;
    prod     = src_a * src_b;
    sum_ovf  = (src_a[MSB] == addend[MSB]) && (sum[MSB] != src_a[MSB]);
    diff_ovf = (src_a[MSB] != src_b[MSB]) && (diff[MSB] != src_a[MSB]);
    a_lt_b   = $signed(src_a) < $signed(src_b);
    a_eq_b   = src_a == src_b;
    cmp_word = '0;
    if (a_lt_b) begin
      cmp_word[2:0] = CMP_LT;
    end else if (a_eq_b) begin
      cmp_word[2:0] = CMP_EQ;
    end else begin
      cmp_word[2:0] = CMP_GT;
    end
  end

  always_comb begin
    res   = '0;
    ovf   = 1'b0;
    legal = 1'b1;
    case (opcode)
      OP_ADD:   begin res = sum;  ovf = sum_ovf;  end
      OP_ADDU:  begin res = sum;                  end
      OP_SUB:   begin res = diff; ovf = diff_ovf; end
      OP_SUBU:  begin res = diff;                 end
      OP_ADDI:  begin res = sum;  ovf = sum_ovf;  end
      OP_ADDIU: begin res = sum;                  end
      OP_CMP:   begin res = cmp_word;             end
      OP_MUL:   begin res = prod;                 end
      default:  begin legal = 1'b0;               end
    endcase
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              ovf,
  output alu_flags_t        flags
);

  logic [PAR_W-1:0] par_chain;

  assign par_chain[0] = res[0];

  genvar gi;
  generate
    for (gi = 1; gi < PAR_W; gi++) begin : g_par
      assign par_chain[gi] = par_chain[gi-1] ^ res[gi];
    end
  endgenerate

  always_comb begin
    flags.par  = ~par_chain[PAR_W-1];
    flags.zero = (res == '0);
    flags.sign = res[DATA_W-1];
    flags.ovf  = ovf;
  end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int PAR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              rd_we,
  output logic [DATA_W-1:0] status
);

  logic              rst_n_sync;
  logic [DATA_W-1:0] dp_res;
  logic              dp_ovf;
  logic              dp_legal;
  alu_flags_t        flags;
  logic              upd_en;
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] result_d, result_q;
  logic [DATA_W-1:0] status_d, status_q;
  logic              we_d, we_q;

  alu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_datapath (
    .opcode (opcode),
    .src_a  (src_a),
    .src_b  (src_b),
    .imm    (imm),
    .res    (dp_res),
    .ovf    (dp_ovf),
    .legal  (dp_legal)
  );

  alu_flag_gen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_flag_gen (
    .res   (dp_res),
    .ovf   (dp_ovf),
    .flags (flags)
  );

  always_comb begin
    status_word              = '0;
    status_word[ST_PAR_BIT]  = flags.par;
    status_word[ST_ZERO_BIT] = flags.zero;
    status_word[ST_SIGN_BIT] = flags.sign;
    status_word[ST_OVF_BIT]  = flags.ovf;
  end

  always_comb begin
    upd_en   = in_valid && dp_legal;
    we_d     = upd_en;
    result_d = upd_en ? dp_res      : result_q;
    status_d = upd_en ? status_word : status_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      result_q <= '0;
      status_q <= '0;
      we_q     <= 1'b0;
    end else begin
      result_q <= result_d;
      status_q <= status_d;
      we_q     <= we_d;
    end
  end

  assign result = result_q;
  assign status = status_q;
  assign rd_we  = we_q;

endmodule

// File: rtl/alu_exec_core_chk.sv
module alu_exec_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [5:0]        opcode,
  input logic [DATA_W-1:0] result,
  input logic              rd_we,
  input logic [DATA_W-1:0] status
);

  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(32'h0000_08C4);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~FLAG_MASK) == '0);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 6'd1 || opcode == 6'd3 || opcode == 6'd5 ||
                  opcode == 6'd6 || opcode == 6'd7)) |=> !status[11]);

  a_r5_cmp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 6'd6) |=> ($countones(result) == 1 && result < 8));

  a_r8_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (status[6] == (result == '0)) && (status[7] == result[DATA_W-1]));

  a_r9_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > 6'd7) |=> (!rd_we && $stable(status) && $stable(result)));

  a_r10_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode <= 6'd7) |=> rd_we);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!rd_we && $stable(status)));

endmodule

bind alu_exec_core alu_exec_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opcode   (opcode),
  .result   (result),
  .rd_we    (rd_we),
  .status   (status)
);

// File: tb/alu_exec_core_tb.sv
module alu_exec_core_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [5:0]  opcode;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic [15:0] imm;
  logic [31:0] result;
  logic        rd_we;
  logic [31:0] status;

  int total;
  int bad;
  logic [31:0] exp_res;
  logic [31:0] exp_st;

  alu_exec_core u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .opcode   (opcode),
    .src_a    (src_a),
    .src_b    (src_b),
    .imm      (imm),
    .result   (result),
    .rd_we    (rd_we),
    .status   (status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [5:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] iv);
    logic [32:0] wide;
    logic [31:0] res;
    logic [31:0] ext;
    logic        ovf;
    logic [31:0] st;
    string       rtag;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; src_a = a; src_b = b; imm = iv;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ext  = {{16{iv[15]}}, iv};
    ovf  = 1'b0;
    res  = 32'h0;
    rtag = "R1";
    case (op)
      6'd0, 6'd1: begin
        wide = {a[31], a} + {b[31], b};
        res  = wide[31:0];
        ovf  = (op == 6'd0) && (wide[32] != wide[31]);
      end
      6'd2, 6'd3: begin
        wide = {a[31], a} - {b[31], b};
        res  = wide[31:0];
        ovf  = (op == 6'd2) && (wide[32] != wide[31]);
      end
      6'd4, 6'd5: begin
        wide = {a[31], a} + {ext[31], ext};
        res  = wide[31:0];
        ovf  = (op == 6'd4) && (wide[32] != wide[31]);
        rtag = "R6";
      end
      6'd6: begin
        rtag = "R5";
        if ($signed(a) < $signed(b)) res = 32'd1;
        else if (a == b)             res = 32'd2;
        else                         res = 32'd4;
      end
      6'd7: res = a * b;
      default: ;
    endcase
    if (op < 6'd8) begin
      st = 32'h0;
      st[2]  = ($countones(res[7:0]) % 2) == 0;
      st[6]  = (res == 32'h0);
      st[7]  = res[31];
      st[11] = ovf;
      exp_res = res;
      exp_st  = st;
      chk("R10", {31'h0, rd_we}, 32'h1);
      chk(rtag, result, exp_res);
      chk("R7", {31'h0, status[2]}, {31'h0, exp_st[2]});
      chk("R8", {30'h0, status[7], status[6]}, {30'h0, exp_st[7], exp_st[6]});
      if (op == 6'd0 || op == 6'd2 || op == 6'd4)
        chk("R3", {31'h0, status[11]}, {31'h0, exp_st[11]});
      else
        chk("R4", {31'h0, status[11]}, 32'h0);
      chk("R2", status & ~32'h0000_08C4, 32'h0);
    end else begin
      chk("R9", {31'h0, rd_we}, 32'h0);
      chk("R9", result, exp_res);
      chk("R9", status, exp_st);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] va [12];
    logic [31:0] vb [12];
    logic [15:0] vi [12];
    total = 0; bad = 0;
    in_valid = 1'b0; opcode = '0; src_a = '0; src_b = '0; imm = '0;
    rst_n = 1'b0;
    va[0]  = 32'h7FFF_FFFF; vb[0]  = 32'h0000_0001; vi[0]  = 16'h0001;
    va[1]  = 32'h8000_0000; vb[1]  = 32'h0000_0001; vi[1]  = 16'hFFFF;
    va[2]  = 32'h8000_0000; vb[2]  = 32'h8000_0000; vi[2]  = 16'h8000;
    va[3]  = 32'h0000_0000; vb[3]  = 32'h0000_0000; vi[3]  = 16'h0000;
    va[4]  = 32'hFFFF_FFFF; vb[4]  = 32'h0000_0001; vi[4]  = 16'h7FFF;
    va[5]  = 32'h0000_0005; vb[5]  = 32'hFFFF_FFFB; vi[5]  = 16'hFFFB;
    va[6]  = 32'h1234_5678; vb[6]  = 32'h1234_5678; vi[6]  = 16'h1234;
    va[7]  = 32'h7FFF_8000; vb[7]  = 32'h8000_0000; vi[7]  = 16'h8000;
    va[8]  = 32'h0001_0000; vb[8]  = 32'h0001_0000; vi[8]  = 16'h00FF;
    va[9]  = 32'h7FFF_FFFF; vb[9]  = 32'hFFFF_FFFF; vi[9]  = 16'h7FFF;
    va[10] = 32'h0000_0003; vb[10] = 32'h0000_0055; vi[10] = 16'h0002;
    va[11] = 32'hDEAD_BEEF; vb[11] = 32'h0000_0010; vi[11] = 16'hF00D;
    repeat (3) @(negedge clk);
    chk("R11", {31'h0, rd_we}, 32'h0);
    chk("R11", result, 32'h0);
    chk("R11", status, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", status, 32'h0);
    exp_res = 32'h0;
    exp_st  = 32'h0;
    for (int p = 0; p < 12; p++) begin
      for (int op = 0; op < 64; op++) begin
        do_op(6'(op), va[p], vb[p], vi[p]);
      end
      do_op(6'd0, va[p], vb[p], vi[p]);
      // R10: strobe low holds state; opcode and operands wiggle meanwhile
      opcode = 6'd2; src_a = ~va[p]; src_b = 32'h0;
      repeat (2) @(negedge clk);
      chk("R10", {31'h0, rd_we}, 32'h0);
      chk("R10", result, exp_res);
      chk("R10", status, exp_st);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule